// File: doc/BRIEF.md
# Cache-Block Operation Gate

This unit sits beside the decode stage of a processor core and screens the cache-block maintenance instructions: write-back of a block (clean), write-back followed by discard (flush), discard without write-back (invalidate) and block zeroing (zero). It takes the instruction word, the base-register value, the current privilege level and the enable fields held in the machine-level and supervisor-level environment configuration registers. It decides whether the instruction is one of these operations and whether the current privilege may issue it. It also settles which operation takes effect: under the configuration an invalidate may be carried out as a flush instead.

The unit rounds the base-register value down to the start of its cache block and hands that address to the memory pipeline. When an external translation or protection checker reports a fault for the request, the unit rewrites load-type causes into store-type causes for the maintenance operations, so that the trap records them as stores. Every result appears one clock cycle after the request, qualified by a valid strobe.

Top module: `cbo_gate`

## Requirements
- R1: A request is recognised only when bits 6:0 are 0001111, bits 14:12 are 010, bits 11:7 are zero and bits 31:20 are 0x000 (invalidate), 0x001 (clean), 0x002 (flush) or 0x004 (zero). Any other word gives `op_recog`=0, `op_illegal`=0 and `op_onehot`=0.
- R2: `out_valid` follows `in_valid` by exactly one cycle, and every output is 0 after reset. A cycle without `in_valid` leaves `blk_addr`, `op_onehot`, `op_illegal` and `op_recog` unchanged.
- R3: Privilege encoding: 00 user, 01 supervisor, 11 machine. Clean and flush are illegal below machine level when `m_cf_en`=0, and at user level when `s_cf_en`=0.
- R4: Zero is illegal below machine level when `m_zero_en`=0, and at user level when `s_zero_en`=0.
- R5: Invalidate is illegal below machine level when `m_inv_ctl` is 00, and at user level when `s_inv_ctl` is 00.
- R6: A legal invalidate is carried out as a flush when a register that governs the current level holds 01 in its invalidate field. The machine-level field governs below machine level and the supervisor-level field governs at user level. Otherwise, including at machine level, the invalidate stays an invalidate.
- R7: The value 10 in either invalidate field has the same effect as 00.
- R8: `blk_addr` is `rs1_val` with the low log2(`BLK_BYTES`) bits cleared. `BLK_BYTES` is a power of two, 64 by default.
- R9: `op_onehot` bit 0 is invalidate, bit 1 clean, bit 2 flush and bit 3 zero. A recognised legal request sets exactly one bit. An illegal request sets none, and then `op_illegal`=1.
- R10: `flt_valid` is 1 only for a recognised legal request with `fault_hit`=1. For clean, flush or invalidate, a load access fault (cause 5) is reported as cause 7 and a load page fault (cause 13) as cause 15. Every other cause, and every cause for zero, passes through unchanged. `flt_cause` is 0 when `flt_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Base-register value |
| priv | input | 2 | Current privilege level |
| m_cf_en | input | 1 | Machine-level clean/flush enable |
| m_zero_en | input | 1 | Machine-level zero enable |
| m_inv_ctl | input | 2 | Machine-level invalidate control |
| s_cf_en | input | 1 | Supervisor-level clean/flush enable |
| s_zero_en | input | 1 | Supervisor-level zero enable |
| s_inv_ctl | input | 2 | Supervisor-level invalidate control |
| fault_hit | input | 1 | External checker reports a fault |
| fault_cause | input | FAULT_W | Cause code from the checker |
| out_valid | output | 1 | Result strobe |
| op_recog | output | 1 | Word is a cache-block operation |
| op_illegal | output | 1 | Operation not permitted at this level |
| op_onehot | output | 4 | Effective operation |
| blk_addr | output | XLEN | Block-aligned address |
| flt_valid | output | 1 | Fault to report |
| flt_cause | output | FAULT_W | Remapped fault cause |

## Verification
On every cycle the assertions check the timing of the strobe and the hold behaviour, the one-hot shape of the operation code and its link to the illegal and recognised flags, the block alignment of the address, that no load-type cause leaves the unit for a maintenance operation, and that machine level is never refused. Which configuration makes which operation illegal, when an invalidate becomes a flush, the treatment of the reserved control value, and the exact address and cause values come only from the bench's sweep. That sweep covers every operation code, privilege level and combination of enable fields.

// File: rtl/cbo_pkg.sv
package cbo_pkg;

   localparam logic [6:0]  CBO_OPCODE = 7'b0001111;
   localparam logic [2:0]  CBO_FUNCT3 = 3'b010;

   localparam logic [11:0] F12_INVAL = 12'h000;
   localparam logic [11:0] F12_CLEAN = 12'h001;
   localparam logic [11:0] F12_FLUSH = 12'h002;
   localparam logic [11:0] F12_ZERO  = 12'h004;

   // one-hot operation positions
   localparam int OP_W     = 4;
   localparam int OP_INVAL = 0;
   localparam int OP_CLEAN = 1;
   localparam int OP_FLUSH = 2;
   localparam int OP_ZERO  = 3;

   typedef logic [1:0] priv_t;
   localparam priv_t PRIV_USER  = 2'b00;
   localparam priv_t PRIV_SUPER = 2'b01;
   localparam priv_t PRIV_MACH  = 2'b11;

   // invalidate control field values
   localparam logic [1:0] INV_OFF      = 2'b00;
   localparam logic [1:0] INV_AS_FLUSH = 2'b01;
   localparam logic [1:0] INV_RSVD     = 2'b10;
   localparam logic [1:0] INV_ON       = 2'b11;

   typedef struct packed {
      logic       cf_en;
      logic       zero_en;
      logic [1:0] inv_ctl;
   } envctl_t;

   typedef struct packed {
      logic            recog;
      logic [OP_W-1:0] req_oh;
   } dec_t;

   function automatic logic [11:0] op_funct12(input int idx);
      case (idx)
         OP_INVAL: return F12_INVAL;
         OP_CLEAN: return F12_CLEAN;
         OP_FLUSH: return F12_FLUSH;
         OP_ZERO:  return F12_ZERO;
         default:  return 12'hfff;
      endcase
   endfunction

endpackage

// File: rtl/cbo_decode.sv
module cbo_decode
   import cbo_pkg::*;
(
   input  logic [31:0] instr,
   output dec_t        dec
);

   logic            base_ok;
   logic [OP_W-1:0] hit;
   logic            unused_rs1_field;

   assign base_ok = (instr[6:0] == CBO_OPCODE) &&
                    (instr[14:12] == CBO_FUNCT3) &&
                    (instr[11:7] == 5'd0);

   generate
      for (genvar g = 0; g < OP_W; g++) begin : g_op
         assign hit[g] = base_ok && (instr[31:20] == op_funct12(g));
      end
   endgenerate

   assign dec.recog  = |hit;
   assign dec.req_oh = hit;

   // register index field is consumed by the register file, not here
   assign unused_rs1_field = ^instr[19:15];

endmodule

// File: rtl/cbo_perm.sv
module cbo_perm
   import cbo_pkg::*;
(
   input  priv_t           priv,
   input  envctl_t         m_ctl,
   input  envctl_t         s_ctl,
   input  dec_t            dec,
   output logic [OP_W-1:0] eff_oh,
   output logic            illegal
);

   // level 0: machine register, level 1: supervisor register
   localparam int N_LVL = 2;

   envctl_t          lvl_ctl [N_LVL];
   logic [N_LVL-1:0] gov;
   logic [N_LVL-1:0] cf_blk;
   logic [N_LVL-1:0] z_blk;
   logic [N_LVL-1:0] inv_blk;
   logic [N_LVL-1:0] inv_fl;

   assign lvl_ctl[0] = m_ctl;
   assign lvl_ctl[1] = s_ctl;

   generate
      for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
         logic [1:0] inv_norm;
         if (g == 0) begin : g_mach
            assign gov[g] = (priv != PRIV_MACH);
         end else begin : g_sup
            assign gov[g] = (priv == PRIV_USER);
         end
         assign inv_norm   = (lvl_ctl[g].inv_ctl == INV_RSVD) ? INV_OFF : lvl_ctl[g].inv_ctl;
         assign cf_blk[g]  = gov[g] & ~lvl_ctl[g].cf_en;
         assign z_blk[g]   = gov[g] & ~lvl_ctl[g].zero_en;
         assign inv_blk[g] = gov[g] & (inv_norm == INV_OFF);
         assign inv_fl[g]  = gov[g] & (inv_norm == INV_AS_FLUSH);
      end
   endgenerate

   always_comb begin
      illegal = dec.recog &
                (((dec.req_oh[OP_CLEAN] | dec.req_oh[OP_FLUSH]) & (|cf_blk)) |
                 (dec.req_oh[OP_ZERO]  & (|z_blk)) |
                 (dec.req_oh[OP_INVAL] & (|inv_blk)));
      eff_oh = '0;
      if (dec.recog && !illegal) begin
         eff_oh = dec.req_oh;
         if (dec.req_oh[OP_INVAL] && (|inv_fl)) begin
            eff_oh[OP_INVAL] = 1'b0;
            eff_oh[OP_FLUSH] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/cbo_fault_map.sv
module cbo_fault_map #(
   parameter int FAULT_W = 5,
   parameter int LD_ACC  = 5,
   parameter int ST_ACC  = 7,
   parameter int LD_PG   = 13,
   parameter int ST_PG   = 15
) (
   input  logic               remap_en,
   input  logic [FAULT_W-1:0] cause_in,
   output logic [FAULT_W-1:0] cause_out
);

   localparam logic [FAULT_W-1:0] C_LD_ACC = FAULT_W'(LD_ACC);
   localparam logic [FAULT_W-1:0] C_ST_ACC = FAULT_W'(ST_ACC);
   localparam logic [FAULT_W-1:0] C_LD_PG  = FAULT_W'(LD_PG);
   localparam logic [FAULT_W-1:0] C_ST_PG  = FAULT_W'(ST_PG);

   generate
      if (LD_ACC >= (1 << FAULT_W) || ST_ACC >= (1 << FAULT_W) ||
          LD_PG  >= (1 << FAULT_W) || ST_PG  >= (1 << FAULT_W)) begin : g_bad_w
         $error("cbo_fault_map: cause codes do not fit FAULT_W");
      end
   endgenerate

   always_comb begin
      cause_out = cause_in;
      if (remap_en) begin
         if (cause_in == C_LD_ACC)     cause_out = C_ST_ACC;
         else if (cause_in == C_LD_PG) cause_out = C_ST_PG;
      end
   end

endmodule

// File: rtl/cbo_align.sv
module cbo_align #(
   parameter int XLEN      = 64,
   parameter int BLK_BYTES = 64
) (
   input  logic [XLEN-1:0] addr_in,
   output logic [XLEN-1:0] addr_out
);

   localparam int              OFS_W = $clog2(BLK_BYTES);
   localparam logic [XLEN-1:0] MASK  = ~(XLEN'(BLK_BYTES) - XLEN'(1));

   generate
      if (BLK_BYTES < 4 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
         $error("cbo_align: BLK_BYTES must be a power of two of at least 4");
      end
      if (OFS_W >= XLEN) begin : g_bad_xlen
         $error("cbo_align: block larger than the address space");
      end
   endgenerate

   assign addr_out = addr_in & MASK;

endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
   import cbo_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int BLK_BYTES = 64,
   parameter int FAULT_W   = 5,
   parameter int LD_ACC    = 5,
   parameter int ST_ACC    = 7,
   parameter int LD_PG     = 13,
   parameter int ST_PG     = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [31:0]        instr,
   input  logic [XLEN-1:0]    rs1_val,
   input  logic [1:0]         priv,
   input  logic               m_cf_en,
   input  logic               m_zero_en,
   input  logic [1:0]         m_inv_ctl,
   input  logic               s_cf_en,
   input  logic               s_zero_en,
   input  logic [1:0]         s_inv_ctl,
   input  logic               fault_hit,
   input  logic [FAULT_W-1:0] fault_cause,
   output logic               out_valid,
   output logic               op_recog,
   output logic               op_illegal,
   output logic [3:0]         op_onehot,
   output logic [XLEN-1:0]    blk_addr,
   output logic               flt_valid,
   output logic [FAULT_W-1:0] flt_cause
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("cbo_gate: XLEN must be 32 or 64");
      end
   endgenerate

   dec_t               dec;
   envctl_t            m_ctl;
   envctl_t            s_ctl;
   logic [OP_W-1:0]    eff_oh;
   logic               illegal;
   logic [XLEN-1:0]    addr_c;
   logic               remap_en;
   logic [FAULT_W-1:0] cause_c;
   logic               flt_c;

   assign m_ctl = '{cf_en: m_cf_en, zero_en: m_zero_en, inv_ctl: m_inv_ctl};
   assign s_ctl = '{cf_en: s_cf_en, zero_en: s_zero_en, inv_ctl: s_inv_ctl};

   cbo_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   cbo_perm u_perm (
      .priv    (priv),
      .m_ctl   (m_ctl),
      .s_ctl   (s_ctl),
      .dec     (dec),
      .eff_oh  (eff_oh),
      .illegal (illegal)
   );

   cbo_align #(.XLEN(XLEN), .BLK_BYTES(BLK_BYTES)) u_align (
      .addr_in  (rs1_val),
      .addr_out (addr_c)
   );

   assign remap_en = eff_oh[OP_INVAL] | eff_oh[OP_CLEAN] | eff_oh[OP_FLUSH];
   assign flt_c    = dec.recog & ~illegal & fault_hit;

   cbo_fault_map #(
      .FAULT_W (FAULT_W), .LD_ACC (LD_ACC), .ST_ACC (ST_ACC),
      .LD_PG   (LD_PG),   .ST_PG  (ST_PG)
   ) u_fmap (
      .remap_en  (remap_en),
      .cause_in  (fault_cause),
      .cause_out (cause_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         op_recog   <= 1'b0;
         op_illegal <= 1'b0;
         op_onehot  <= '0;
         blk_addr   <= '0;
         flt_valid  <= 1'b0;
         flt_cause  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            op_recog   <= dec.recog;
            op_illegal <= illegal;
            op_onehot  <= eff_oh;
            blk_addr   <= addr_c;
            flt_valid  <= flt_c;
            flt_cause  <= flt_c ? cause_c : '0;
         end
      end
   end

endmodule

// File: rtl/cbo_gate_chk.sv
module cbo_gate_chk #(
   parameter int XLEN      = 64,
   parameter int BLK_BYTES = 64,
   parameter int FAULT_W   = 5,
   parameter int LD_ACC    = 5,
   parameter int ST_ACC    = 7,
   parameter int LD_PG     = 13,
   parameter int ST_PG     = 15
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [1:0]         priv,
   input logic               out_valid,
   input logic               op_recog,
   input logic               op_illegal,
   input logic [3:0]         op_onehot,
   input logic [XLEN-1:0]    blk_addr,
   input logic               flt_valid,
   input logic [FAULT_W-1:0] flt_cause
);

   localparam int OFS_W = $clog2(BLK_BYTES);

   a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(blk_addr) && $stable(op_onehot) &&
                     $stable(op_illegal) && $stable(op_recog)));

   a_r1_unrec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !op_recog) |-> (!op_illegal && op_onehot == 4'd0 && !flt_valid));

   a_r9_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot0(op_onehot));

   a_r9_legal_one: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && op_recog && !op_illegal) |-> $onehot(op_onehot));

   a_r9_illegal_none: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && op_illegal) |-> (op_onehot == 4'd0 && !flt_valid));

   a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (blk_addr[OFS_W-1:0] == '0));

   a_r10_no_load_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_valid && !op_onehot[3]) |->
         (flt_cause != FAULT_W'(LD_ACC) && flt_cause != FAULT_W'(LD_PG)));

   a_r10_cause_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_valid |-> (flt_cause == '0));

   // R3 R4 R5: machine level is never refused
   a_r5_machine_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && priv == 2'b11) |=> !op_illegal);

endmodule

bind cbo_gate cbo_gate_chk #(
   .XLEN (XLEN), .BLK_BYTES (BLK_BYTES), .FAULT_W (FAULT_W),
   .LD_ACC (LD_ACC), .ST_ACC (ST_ACC), .LD_PG (LD_PG), .ST_PG (ST_PG)
) u_chk (
   .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .priv (priv),
   .out_valid (out_valid), .op_recog (op_recog), .op_illegal (op_illegal),
   .op_onehot (op_onehot), .blk_addr (blk_addr), .flt_valid (flt_valid),
   .flt_cause (flt_cause)
);

// File: tb/cbo_gate_test.sv
`timescale 1ns/100ps
module cbo_gate_test;

   localparam int XLEN    = 64;
   localparam int BLK     = 64;
   localparam int FAULT_W = 5;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [31:0]        instr = '0;
   logic [XLEN-1:0]    rs1_val = '0;
   logic [1:0]         priv = '0;
   logic               m_cf_en = 1'b0, m_zero_en = 1'b0, s_cf_en = 1'b0, s_zero_en = 1'b0;
   logic [1:0]         m_inv_ctl = '0, s_inv_ctl = '0;
   logic               fault_hit = 1'b0;
   logic [FAULT_W-1:0] fault_cause = '0;
   logic               out_valid, op_recog, op_illegal, flt_valid;
   logic [3:0]         op_onehot;
   logic [XLEN-1:0]    blk_addr;
   logic [FAULT_W-1:0] flt_cause;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   cbo_gate #(.XLEN(XLEN), .BLK_BYTES(BLK), .FAULT_W(FAULT_W)) uut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .instr (instr),
      .rs1_val (rs1_val), .priv (priv), .m_cf_en (m_cf_en), .m_zero_en (m_zero_en),
      .m_inv_ctl (m_inv_ctl), .s_cf_en (s_cf_en), .s_zero_en (s_zero_en),
      .s_inv_ctl (s_inv_ctl), .fault_hit (fault_hit), .fault_cause (fault_cause),
      .out_valid (out_valid), .op_recog (op_recog), .op_illegal (op_illegal),
      .op_onehot (op_onehot), .blk_addr (blk_addr), .flt_valid (flt_valid),
      .flt_cause (flt_cause)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // selector: 0 inval, 1 clean, 2 flush, 3 zero, 4..7 unrecognised words
   function automatic logic [31:0] make_word(input int sel);
      case (sel)
         0: return {12'h000, 5'd7, 3'b010, 5'd0, 7'b0001111};
         1: return {12'h001, 5'd7, 3'b010, 5'd0, 7'b0001111};
         2: return {12'h002, 5'd7, 3'b010, 5'd0, 7'b0001111};
         3: return {12'h004, 5'd7, 3'b010, 5'd0, 7'b0001111};
         4: return {12'h003, 5'd7, 3'b010, 5'd0, 7'b0001111};
         5: return {12'h008, 5'd7, 3'b010, 5'd0, 7'b0001111};
         6: return {12'h000, 5'd7, 3'b011, 5'd0, 7'b0001111};
         default: return {12'h001, 5'd7, 3'b010, 5'd3, 7'b0001111};
      endcase
   endfunction

   initial begin
      #500000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int cnt = 0;
      logic [XLEN-1:0] last_addr;
      logic [3:0]      last_oh;
      repeat (3) @(negedge clk);
      // R2 reset state
      chk(out_valid == 1'b0, "R2 reset valid", 64'(out_valid), 0);
      chk(op_onehot == 4'd0 && !op_illegal && !op_recog, "R2 reset op", 64'(op_onehot), 0);
      chk(blk_addr == '0 && !flt_valid && flt_cause == '0, "R2 reset addr", blk_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int sel = 0; sel < 8; sel++) begin
         for (int pi = 0; pi < 3; pi++) begin
            for (int cfg = 0; cfg < 256; cfg++) begin
               logic [1:0] pv, mi, si, mn, sn;
               bit mgov, sgov, rec, ill, fl, exp_fv;
               logic [3:0] exp_oh;
               logic [FAULT_W-1:0] cin, exp_c;
               pv = (pi == 2) ? 2'b11 : 2'(pi);
               mi = cfg[5:4];
               si = cfg[7:6];
               cin = (cnt % 4 == 0) ? 5'd5 : (cnt % 4 == 1) ? 5'd13 :
                     (cnt % 4 == 2) ? 5'd7 : 5'd2;
               instr       = make_word(sel);
               rs1_val     = {32'h9e37_79b9 ^ 32'(cnt), 32'(cnt * 40503 + 17)};
               priv        = pv;
               m_cf_en     = cfg[0];
               s_cf_en     = cfg[1];
               m_zero_en   = cfg[2];
               s_zero_en   = cfg[3];
               m_inv_ctl   = mi;
               s_inv_ctl   = si;
               fault_hit   = ((cnt / 4) % 2) == 1;
               fault_cause = cin;
               in_valid    = 1'b1;

               // expected values from the requirements
               mgov = (pv != 2'b11);
               sgov = (pv == 2'b00);
               mn = (mi == 2'b10) ? 2'b00 : mi;   // R7
               sn = (si == 2'b10) ? 2'b00 : si;
               rec = (sel < 4);
               ill = 1'b0;
               fl  = 1'b0;
               if (sel == 1 || sel == 2) ill = (mgov && !cfg[0]) || (sgov && !cfg[1]);
               if (sel == 3)             ill = (mgov && !cfg[2]) || (sgov && !cfg[3]);
               if (sel == 0) begin
                  ill = (mgov && mn == 2'b00) || (sgov && sn == 2'b00);
                  fl  = (mgov && mn == 2'b01) || (sgov && sn == 2'b01);
               end
               exp_oh = 4'd0;
               if (rec && !ill) exp_oh = (sel == 0 && fl) ? 4'b0100 : 4'(1 << sel);
               exp_fv = rec && !ill && fault_hit;
               exp_c  = cin;
               if (exp_oh[3] == 1'b0 && cin == 5'd5)  exp_c = 5'd7;
               if (exp_oh[3] == 1'b0 && cin == 5'd13) exp_c = 5'd15;
               if (!exp_fv) exp_c = '0;

               @(negedge clk);
               chk(out_valid == 1'b1, "R2 valid latency", 64'(out_valid), 1);
               chk(op_recog == rec, "R1 recognition", 64'(op_recog), 64'(rec));
               chk(op_illegal == ill, (sel == 0) ? "R5 R7 invalidate permission" :
                   (sel == 3) ? "R4 zero permission" : "R3 clean/flush permission",
                   64'(op_illegal), 64'(ill));
               chk(op_onehot == exp_oh, (sel == 0) ? "R6 invalidate upgrade" : "R9 op code",
                   64'(op_onehot), 64'(exp_oh));
               chk(blk_addr == (rs1_val & ~64'(BLK - 1)), "R8 alignment",
                   blk_addr, rs1_val & ~64'(BLK - 1));
               chk(flt_valid == exp_fv, "R10 fault valid", 64'(flt_valid), 64'(exp_fv));
               chk(flt_cause == exp_c, "R10 fault cause", 64'(flt_cause), 64'(exp_c));
               cnt++;
            end
         end
      end

      // R2: idle cycle leaves results untouched
      last_addr = blk_addr;
      last_oh   = op_onehot;
      in_valid  = 1'b0;
      rs1_val   = 64'h1234_5678_9abc_def0;
      instr     = make_word(3);
      priv      = 2'b11;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 idle valid", 64'(out_valid), 0);
      chk(blk_addr == last_addr, "R2 idle hold addr", blk_addr, last_addr);
      chk(op_onehot == last_oh, "R2 idle hold op", 64'(op_onehot), 64'(last_oh));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule